// File: doc/BRIEF.md
# Indexed Chipset Control Register Port

This block puts a small bank of chipset control registers behind two byte-wide I/O addresses. Software first writes a register number to the index address. It then reads or writes that register through the data address. Each implemented register has its own mask of writable bits. A write stores the data ANDed with that mask, so bits outside the mask read back as zero.

One register bit is decoded live as the DMA address-width mode. The currently latched index is also driven on a separate mirror output, for a second configuration read path. A third I/O address returns a fixed identification byte. Any other address that is read returns all ones.

Register numbers (hexadecimal) follow the system map: 01 and 70 through 76. Reads use a strobe and return data one clock later. Writes take effect on the clock edge that samples the strobe.

Top module: `cfg_index_port`

## Requirements
- R1: A write strobe at address 0x0022 stores the data byte as the current index. The index resets to 0x00 and is always visible on `idx_mirror`.
- R2: A write strobe at address 0x0023 stores `data & mask` into the register selected by the index. The masks are: 01 → 0xFF, 70 → 0xC0, 71 → 0xF6, 72 → 0xFF, 73 → 0xFD, 74 → 0xFF, 75 → 0xFC, 76 → 0xFF.
- R3: A data-port write while the index names no implemented register changes no register. A data-port read of such an index returns 0x00. Write strobes at any address other than 0x0022 or 0x0023 change nothing.
- R4: A read strobe at address 0x0023 loads `io_rdata` with the selected register. The value appears on the clock edge that samples the strobe, so it is seen one cycle after the strobe.
- R5: After reset every register reads 0x00, except 01 = 0xC0, 71 = 0x01, 72 = 0xFF and 76 = 0xFF.
- R6: `dma_wide` equals bit 7 of register 75: 1 selects 32-bit DMA addressing and 0 selects 24-bit. It is 0 after reset.
- R7: A read strobe at address 0x0033 returns 0x3C.
- R8: A read strobe at any other address, the index address 0x0022 included, returns 0xFF.
- R9: `io_rdata` resets to 0x00 and holds its value in cycles without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Single-cycle write strobe |
| io_rd | input | 1 | Single-cycle read strobe |
| io_rdata | output | 8 | Registered read data |
| dma_wide | output | 1 | DMA address width: 1 = 32-bit, 0 = 24-bit |
| idx_mirror | output | 8 | Currently latched index |

## Verification
A write updates the index, the register and `dma_wide` on the edge that samples the strobe. These results are therefore due one cycle after the strobe is raised. A read strobe also loads `io_rdata` on that edge, so read data is due one cycle later. The bench raises every strobe at a falling edge and lowers it at the next falling edge. It samples outputs only at that second falling edge, half a cycle after the register that produced them was updated.

// File: rtl/cfg_index_port.sv
module cfg_index_port #(
  parameter logic [15:0] IDX_PORT  = 16'h0022,
  parameter logic [15:0] DATA_PORT = 16'h0023,
  parameter logic [15:0] ID_PORT   = 16'h0033,
  parameter logic [7:0]  ID_VALUE  = 8'h3C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] io_addr,
  input  logic [7:0]  io_wdata,
  input  logic        io_wr,
  input  logic        io_rd,
  output logic [7:0]  io_rdata,
  output logic        dma_wide,
  output logic [7:0]  idx_mirror
);
  localparam int NREG = 8;
  localparam int SW   = $clog2(NREG);
  localparam int DMA_SLOT = 6;

  function automatic logic [7:0] mask_of(logic [SW-1:0] s);
    case (s)
      3'd1: return 8'hC0;
      3'd2: return 8'hF6;
      3'd4: return 8'hFD;
      3'd6: return 8'hFC;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] init_of(logic [SW-1:0] s);
    case (s)
      3'd0: return 8'hC0;
      3'd2: return 8'h01;
      3'd3: return 8'hFF;
      3'd7: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  logic [7:0]    idx_q;
  logic [7:0]    bank [NREG];
  logic          hit;
  logic [SW-1:0] slot;
  logic [7:0]    rd_next;

  always_comb begin
    hit  = 1'b0;
    slot = '0;
    if (idx_q == 8'h01) begin
      hit = 1'b1;
    end else if (idx_q[7:3] == 5'b01110 && idx_q[2:0] != 3'd7) begin
      hit  = 1'b1;
      slot = idx_q[2:0] + 3'd1;
    end
  end

  always_comb begin
    if (io_addr == DATA_PORT)    rd_next = hit ? bank[slot] : 8'h00;
    else if (io_addr == ID_PORT) rd_next = ID_VALUE;
    else                         rd_next = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q    <= 8'h00;
      io_rdata <= 8'h00;
      for (int s = 0; s < NREG; s++) bank[s] <= init_of(SW'(s));
    end else begin
      if (io_wr && io_addr == IDX_PORT)
        idx_q <= io_wdata;
      else if (io_wr && io_addr == DATA_PORT && hit)
        bank[slot] <= io_wdata & mask_of(slot);
      if (io_rd)
        io_rdata <= rd_next;
    end
  end

  assign dma_wide   = bank[DMA_SLOT][7];
  assign idx_mirror = idx_q;
endmodule

// File: rtl/cfg_index_port_chk.sv
module cfg_index_port_chk #(
  parameter logic [15:0] IDX_PORT  = 16'h0022,
  parameter logic [15:0] DATA_PORT = 16'h0023,
  parameter logic [15:0] ID_PORT   = 16'h0033,
  parameter logic [7:0]  ID_VALUE  = 8'h3C
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] io_addr,
  input logic [7:0]  io_wdata,
  input logic        io_wr,
  input logic        io_rd,
  input logic [7:0]  io_rdata,
  input logic        dma_wide,
  input logic [7:0]  idx_mirror
);
  a_r1_index_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == IDX_PORT) |=> (idx_mirror == $past(io_wdata)));

  a_r1_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && io_addr == IDX_PORT) |=> $stable(idx_mirror));

  a_r6_dma_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && io_addr == DATA_PORT) |=> $stable(dma_wide));

  a_r7_id_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == ID_PORT) |=> (io_rdata == ID_VALUE));

  a_r8_unhandled_read: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr != DATA_PORT && io_addr != ID_PORT) |=> (io_rdata == 8'hFF));

  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> $stable(io_rdata));
endmodule

bind cfg_index_port cfg_index_port_chk #(
  .IDX_PORT(IDX_PORT), .DATA_PORT(DATA_PORT), .ID_PORT(ID_PORT), .ID_VALUE(ID_VALUE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
  .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
  .dma_wide(dma_wide), .idx_mirror(idx_mirror)
);

// File: tb/cfg_index_port_tb.sv
`timescale 1ns/1ps
module cfg_index_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_rdata;
  logic        dma_wide;
  logic [7:0]  idx_mirror;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  cfg_index_port dut_i (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
    .dma_wide(dma_wide), .idx_mirror(idx_mirror)
  );

  // {index, write data, expected readback}
  localparam logic [23:0] VEC [12] = '{
    24'h01_A5_A5, 24'h70_FF_C0, 24'h71_FF_F6, 24'h72_12_12,
    24'h73_FF_FD, 24'h74_5A_5A, 24'h76_00_00, 24'h70_3F_00,
    24'h02_FF_00, 24'h6F_FF_00, 24'h77_FF_00, 24'hFF_FF_00
  };

  localparam logic [7:0] RIDX [8] = '{8'h01, 8'h70, 8'h71, 8'h72, 8'h73, 8'h74, 8'h75, 8'h76};
  localparam logic [7:0] RDEF [8] = '{8'hC0, 8'h00, 8'h01, 8'hFF, 8'h00, 8'h00, 8'h00, 8'hFF};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  task automatic reg_rd(input logic [7:0] ix, output logic [7:0] d);
    wr(16'h0022, ix);
    rd(16'h0023, d);
  endtask

  task automatic check_defaults(input string tag);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) begin
      reg_rd(RIDX[i], v);
      chk({"R5 ", tag}, v, RDEF[i]);
    end
    chk({"R6 ", tag}, {7'd0, dma_wide}, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] held;
    repeat (3) @(negedge clk);
    chk("R9 rdata reset", io_rdata, 8'h00);
    chk("R1 index reset", idx_mirror, 8'h00);
    chk("R6 dma reset", {7'd0, dma_wide}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check_defaults("defaults");

    for (int i = 0; i < 12; i++) begin
      wr(16'h0022, VEC[i][23:16]);
      chk("R1 mirror", idx_mirror, VEC[i][23:16]);
      wr(16'h0023, VEC[i][15:8]);
      rd(16'h0023, v);
      chk("R2/R3 masked readback", v, VEC[i][7:0]);
    end

    wr(16'h0022, 8'h75);
    wr(16'h0023, 8'hFF);
    chk("R6 dma wide set", {7'd0, dma_wide}, 8'h01);
    rd(16'h0023, v);
    chk("R2 reg75 mask", v, 8'hFC);
    wr(16'h0023, 8'h7F);
    chk("R6 dma narrow", {7'd0, dma_wide}, 8'h00);
    rd(16'h0023, v);
    chk("R2 reg75 readback", v, 8'h7C);

    wr(16'h0022, 8'h74);
    wr(16'h0024, 8'h99);
    wr(16'h0033, 8'h99);
    rd(16'h0023, v);
    chk("R3 stray write ignored", v, 8'h5A);
    chk("R1 index after stray", idx_mirror, 8'h74);

    rd(16'h0033, v);
    chk("R7 id byte", v, 8'h3C);
    rd(16'h0022, v);
    chk("R8 index port read", v, 8'hFF);
    rd(16'h0080, v);
    chk("R8 other read", v, 8'hFF);

    wr(16'h0022, 8'h01);
    rd(16'h0023, v);
    chk("R4 read latency", v, 8'hA5);
    held = io_rdata;
    wr(16'h0023, 8'h11);
    repeat (3) @(negedge clk);
    chk("R9 rdata held", io_rdata, held);

    wr(16'h0022, 8'h75);
    wr(16'h0023, 8'h80);
    chk("R6 dma before reset", {7'd0, dma_wide}, 8'h01);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 index mid reset", idx_mirror, 8'h00);
    chk("R6 dma mid reset", {7'd0, dma_wide}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check_defaults("after reset");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule